// File: doc/BRIEF.md
# Single-Wire Pulse-Count Limit Decoder

This block turns a burst of pulses on one enable/programming input into a 4-bit peak-current-limit selector and the matching percentage of full current. The same input that enables the charger carries the burst: the first rising edge opens a fixed setup window, the first high phase must be long enough to be taken as a real request, and each later qualified rising edge inside the window raises the selector by one. When the window closes, a one-cycle strobe tells the charging controller that it may start, and the selection is held for as long as the input stays high.

The input is brought into the clock domain through two flops. Every timing threshold is a parameter counted in clock cycles. With the defaults and a 50 MHz clock, the window is 200 us, the first high phase must last at least 15 us, and a low gap must last at least 0.2 us. Holding the input low after setup clears the selection, so the next burst can pick a different level.

Top module: `pulse_limit_decoder`

## Requirements
- R1: After reset, code is 0, pct is 100 and setup_done is 0.
- R2: A rising edge of the synchronized input while idle starts a burst. If fewer than FIRST_MIN_CYC consecutive high samples follow, counting the first one, the burst is rejected: code stays 0 and setup_done does not pulse.
- R3: After an accepted first pulse, a rising edge inside the window adds one to the count only if the input was low for at least MIN_PHASE_CYC consecutive synchronized samples just before it. A shorter low gap adds nothing.
- R4: The window lasts WINDOW_CYC synchronized samples, starting with the first high sample. When it closes, setup_done is 1 for exactly one cycle and code takes the number of counted edges.
- R5: The count stops at 15, so a burst of 15 or more extra pulses gives code 15.
- R6: pct is looked up from code: 0→100, 1→95, 2→90, 3→86, 4→81, 5→76, 6→71, 7→67, 8→62, 9→57, 10→52, 11→48, 12→43, 13→38, 14→33, 15→29.
- R7: While a burst is being decoded, code stays 0 and pct stays 100.
- R8: After the window closes, code is held while the input is high. A single low synchronized sample changes nothing. Two consecutive low samples clear code to 0 and return the block to idle.
- R9: After a clear, a new burst selects a new level.
- R10: A rising edge that follows a single-sample low, while the setting is held, does not change code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Enable/programming input, asynchronous to clk |
| code | output | 4 | Selected limit step, 0 meaning full current |
| pct | output | 7 | Limit as a percentage of full current |
| setup_done | output | 1 | One-cycle strobe when the setup window closes |

## Verification
A wrong internal count shows only when the window closes: code and pct take a wrong value in the same cycle that setup_done pulses, about WINDOW_CYC plus two cycles after the first edge. A wrong phase state shows sooner. A missed clear leaves code nonzero two cycles after a low level. A window timer that runs long or short moves the strobe by that many cycles. The bench's per-cycle model catches every one of these in the first cycle where it diverges, and does not wait for the end-of-burst checks.

// File: rtl/pulse_limit_decoder.sv
module pulse_limit_decoder #(
  parameter int MIN_PHASE_CYC = 10,
  parameter int FIRST_MIN_CYC = 750,
  parameter int WINDOW_CYC    = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_in,
  output logic [3:0] code,
  output logic [6:0] pct,
  output logic       setup_done
);

  localparam int TW = $clog2(WINDOW_CYC + 1);
  localparam int LW = $clog2(MIN_PHASE_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_WIN, S_HOLD} st_t;

  st_t           state;
  logic          s1, s2, prev;
  logic [TW-1:0] win_cnt;
  logic [LW-1:0] low_cnt;
  logic [3:0]    cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, prev} <= '0;
    else        {s1, s2, prev} <= {pin_in, s1, s2};

  wire rise    = s2 & ~prev;
  wire gap_ok  = (low_cnt == LW'(MIN_PHASE_CYC));
  wire [3:0] cnt_nx = (rise && gap_ok && cnt != 4'hF) ? cnt + 4'd1 : cnt;
  wire win_end = (win_cnt == TW'(WINDOW_CYC - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       low_cnt <= '0;
    else if (s2)      low_cnt <= '0;
    else if (!gap_ok) low_cnt <= low_cnt + LW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      win_cnt    <= '0;
      cnt        <= '0;
      code       <= '0;
      setup_done <= 1'b0;
    end else begin
      setup_done <= 1'b0;
      case (state)
        S_IDLE:
          if (rise) begin
            state   <= S_FIRST;
            win_cnt <= TW'(1);
            cnt     <= '0;
          end
        S_FIRST:
          if (!s2) state <= S_IDLE;
          else begin
            if (win_cnt == TW'(FIRST_MIN_CYC - 1)) state <= S_WIN;
            win_cnt <= win_cnt + TW'(1);
          end
        S_WIN: begin
          cnt     <= cnt_nx;
          win_cnt <= win_cnt + TW'(1);
          if (win_end) begin
            state      <= S_HOLD;
            code       <= cnt_nx;
            setup_done <= 1'b1;
          end
        end
        default:
          if (!s2 && !prev) begin
            state <= S_IDLE;
            code  <= '0;
          end
      endcase
    end
  end

  always_comb
    case (code)
      4'd0:    pct = 7'd100;
      4'd1:    pct = 7'd95;
      4'd2:    pct = 7'd90;
      4'd3:    pct = 7'd86;
      4'd4:    pct = 7'd81;
      4'd5:    pct = 7'd76;
      4'd6:    pct = 7'd71;
      4'd7:    pct = 7'd67;
      4'd8:    pct = 7'd62;
      4'd9:    pct = 7'd57;
      4'd10:   pct = 7'd52;
      4'd11:   pct = 7'd48;
      4'd12:   pct = 7'd43;
      4'd13:   pct = 7'd38;
      4'd14:   pct = 7'd33;
      default: pct = 7'd29;
    endcase

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    setup_done |=> !setup_done); // R4

  AST_DONE_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    setup_done |-> state == S_HOLD); // R4

  AST_SHORT_FIRST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FIRST && !s2) |=> (state == S_IDLE && !setup_done && code == 4'd0)); // R2

  AST_DEFAULT_OUTSIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    state != S_HOLD |-> (code == 4'd0 && pct == 7'd100)); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD && (s2 || prev)) |=> $stable(code)); // R8

  AST_CLEAR_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD && !s2 && !prev) |=> (code == 4'd0 && state == S_IDLE)); // R8

  AST_PCT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pct >= 7'd29 && pct <= 7'd100); // R6

endmodule

// File: tb/tb_pulse_limit_decoder.sv
module tb_pulse_limit_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int MINP = 3;
  localparam int FMIN = 20;
  localparam int WIN  = 200;

  logic clk = 0, rst_n = 0, pin = 0;
  logic [3:0] code;
  logic [6:0] pct;
  logic setup_done;

  pulse_limit_decoder #(.MIN_PHASE_CYC(MINP), .FIRST_MIN_CYC(FMIN), .WINDOW_CYC(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin), .code(code), .pct(pct), .setup_done(setup_done));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, dones = 0;
  int ptab[16] = '{100, 95, 90, 86, 81, 76, 71, 67, 62, 57, 52, 48, 43, 38, 33, 29};

  // behavioural reference: phase 0 idle, 1 first pulse, 2 window, 3 holding
  bit hist[$];
  int m_phase = 0, m_age = 0, m_lows = 0, m_edges = 0, m_code = 0;
  bit m_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete(); m_phase = 0; m_age = 0; m_lows = 0; m_edges = 0; m_code = 0; m_done = 0;
    end else begin
      bit cur, old;
      hist.push_front(pin);
      if (hist.size() > 4) void'(hist.pop_back());
      cur = (hist.size() > 2) ? hist[2] : 1'b0;
      old = (hist.size() > 3) ? hist[3] : 1'b0;
      m_done = 0;
      if (m_phase == 0) begin
        if (cur && !old) begin m_phase = 1; m_age = 1; m_edges = 0; end
      end else if (m_phase == 1) begin
        if (!cur) m_phase = 0;
        else begin
          if (m_age + 1 >= FMIN) m_phase = 2;
          m_age++;
        end
      end else if (m_phase == 2) begin
        if (cur && !old && m_lows >= MINP && m_edges < 15) m_edges++;
        if (m_age + 1 == WIN) begin m_phase = 3; m_code = m_edges; m_done = 1; end
        m_age++;
      end else if (!cur && !old) begin
        m_phase = 0; m_code = 0;
      end
      m_lows = cur ? 0 : ((m_lows < MINP) ? m_lows + 1 : MINP);
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (setup_done) dones++;
    check(code == 4'(m_code), "R3/R4/R8 model code", code, m_code);
    check(pct == 7'(ptab[m_code]), "R6 model pct", pct, ptab[m_code]);
    check(setup_done == m_done, "R4 model strobe", setup_done, m_done);
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic burst(int first_hi, int n, int lo, int hi);
    pin = 1; idle(first_hi);
    for (int i = 0; i < n; i++) begin
      pin = 0; idle(lo);
      pin = 1; idle(hi);
    end
  endtask

  task automatic clear_pin(); pin = 0; idle(10); endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d0;
    idle(3);
    check(code == 0 && pct == 100 && !setup_done, "R1 in reset", code, 0);
    rst_n = 1; idle(5);
    check(code == 0, "R1 code after reset", code, 0);
    check(pct == 100, "R1 pct after reset", pct, 100);

    // R3 R6 R9: every level through successive bursts
    for (int k = 0; k < 16; k++) begin
      clear_pin();
      check(code == 0, "R8 cleared before burst", code, 0);
      d0 = dones;
      burst(FMIN + 2, k, MINP, MINP);
      check(code == 0 && pct == 100, "R7 default during window", code, 0);
      idle(WIN + 10);
      check(code == 4'(k), "R3 R9 code after burst", code, k);
      check(pct == 7'(ptab[k]), "R6 pct after burst", pct, ptab[k]);
      check(dones == d0 + 1, "R4 one strobe per burst", dones - d0, 1);
    end

    // R5: saturation
    clear_pin();
    burst(FMIN, 20, MINP, MINP); idle(WIN + 10);
    check(code == 15, "R5 saturated code", code, 15);
    check(pct == 29, "R5 saturated pct", pct, 29);

    // R2: short first pulse rejected
    clear_pin(); d0 = dones;
    burst(FMIN - 5, 0, 0, 0); pin = 0; idle(WIN + 20);
    check(code == 0, "R2 reject code", code, 0);
    check(dones == d0, "R2 reject no strobe", dones - d0, 0);

    // R3: short gaps not counted
    clear_pin();
    burst(FMIN, 3, MINP, MINP);
    burst(0, 2, MINP - 1, MINP);
    idle(WIN + 10);
    check(code == 3, "R3 short gaps ignored", code, 3);

    // R8 R10: single low sample and following edge ignored while holding
    clear_pin();
    burst(FMIN, 5, MINP, MINP); idle(WIN + 10);
    check(code == 5, "R8 held code", code, 5);
    pin = 0; idle(1); pin = 1; idle(10);
    check(code == 5, "R10 glitch edge ignored", code, 5);
    check(pct == 76, "R10 pct unchanged", pct, 76);
    pin = 0; idle(2); pin = 1; idle(4);
    check(code == 0, "R8 two lows clear", code, 0);
    idle(WIN + 10);
    check(code == 0, "R9 plain high burst default", code, 0);

    clear_pin();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule